// File: doc/BRIEF.md
# Supply Supervisor Reset Generator

This block produces the system reset of a chip from three kinds of request. The first is a digital indication that the supply rail is above its trip point. The analog comparator, its hysteresis and its glitch rejection sit upstream and are summarised by that one input. The second is a pair of manual-reset inputs, one active-low and one active-high. The third is a timeout pulse from a watchdog. The block drives a complementary pair of reset outputs, one active-high and one active-low. It also drives a busy flag that the memory interface uses to refuse accesses while reset is in force.

While the supply is low, reset is held. Once the supply is good, reset stays on for a fixed number of clock cycles and is then released. If the supply drops again, reset returns on the next clock edge. The manual inputs are synchronised and then edge-sensed. The active transition of either input starts a timeout of fixed length, and the timeout ends on schedule even if the input is held active. A watchdog pulse starts the same timeout. Any new trigger that arrives during a timeout reloads the count.

Top module: `supv_rst_gen`

## Requirements
- R1: While `supply_ok` is sampled low at a rising edge, the outputs after that edge are in the active state: `rst_out_hi`=1, `rst_out_lo`=0, `busy`=1.
- R2: After `supply_ok` goes high, with no other trigger, the outputs release (`rst_out_hi`=0, `rst_out_lo`=1, `busy`=0) at the TIMEOUT_CYC-th rising edge that samples it high. The first such edge counts as edge 1.
- R3: If `supply_ok` falls while reset is released, the outputs become active at the very next rising edge, with no delay.
- R4: A high-to-low transition on `mr_n_pin` is a trigger. It passes SYNC_STAGES synchroniser flops and takes effect at edge SYNC_STAGES+1 after the change, where edge 1 is the first edge that samples the new level. From that edge the outputs are active for exactly TIMEOUT_CYC cycles.
- R5: A low-to-high transition on `mr_pin` is a trigger, with the same latency and duration as in R4.
- R6: A manual input held in its active level beyond the timeout does not extend reset. Its return to the inactive level does not assert reset either.
- R7: A `wdt_expire` pulse sampled high at a rising edge makes the outputs active after that edge. They release TIMEOUT_CYC edges later.
- R8: A trigger that arrives while a timeout is running restarts the count. The release then falls TIMEOUT_CYC edges after the newest trigger.
- R9: `rst_out_lo` is always the complement of `rst_out_hi`, and `busy` always equals `rst_out_hi`.
- R10: While `rst` is high the outputs are active. After `rst` falls, with the supply good, release follows the timing of R2.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset of the block's own state |
| supply_ok | input | 1 | High when the supply rail is above the trip point, already filtered |
| mr_n_pin | input | 1 | Active-low manual reset request; its falling edge triggers |
| mr_pin | input | 1 | Active-high manual reset request; its rising edge triggers |
| wdt_expire | input | 1 | One-cycle watchdog timeout pulse, synchronous to clk |
| rst_out_hi | output | 1 | Reset output, high when active |
| rst_out_lo | output | 1 | Reset output, low when active |
| busy | output | 1 | High while reset is in force; gates the memory interface |

## Verification
On every cycle, the embedded properties check the following. A low supply forces the active state on the next edge. Any manual or watchdog trigger leads to an active output. A release happens only while the supply is good. The three output flops stay consistent with one another. The counter never exceeds its load value, and an edge pulse lasts only one cycle.

Only the directed scenarios can show the exact cycle of release after power-up, after a manual edge and after a watchdog pulse. They also show that a held manual input does not stretch reset and that its trailing edge is ignored. Finally, they show that a second trigger moves the release point out.

// File: rtl/supv_pkg.sv
package supv_pkg;

    // Phase of the reset timer
    typedef enum logic [1:0] {
        TM_HOLD  = 2'd0,   // supply below trip point, count parked at full load
        TM_COUNT = 2'd1,   // timeout running
        TM_IDLE  = 2'd2    // reset released
    } tm_state_e;

    // Reasons the timer may be (re)loaded in a cycle
    typedef struct packed {
        logic supply_low;
        logic manual;
        logic watchdog;
    } supv_cause_t;

    localparam int unsigned SUPV_SYNC_DEFAULT = 2;

    // A cause that restarts a timeout while the supply is good
    function automatic logic cause_restarts(supv_cause_t c);
        return c.manual | c.watchdog;
    endfunction

    // Counter width for a load value
    function automatic int unsigned cnt_width(int unsigned load);
        return (load < 2) ? 1 : $clog2(load + 1);
    endfunction

endpackage

// File: rtl/supv_mr_edge.sv
module supv_mr_edge
    import supv_pkg::*;
#(
    parameter int unsigned SYNC_STAGES = SUPV_SYNC_DEFAULT,
    parameter bit          ACTIVE_HIGH = 1'b1
) (
    input  logic clk,
    input  logic rst,
    input  logic pin,
    output logic trig
);
    localparam logic IDLE_LVL = ACTIVE_HIGH ? 1'b0 : 1'b1;
    localparam int unsigned LAST = SYNC_STAGES - 1;

    logic [SYNC_STAGES-1:0] chain;
    logic                   act_lvl;
    logic                   act_prev;

    for (genvar i = 0; i < SYNC_STAGES; i++) begin : g_sync
        if (i == 0) begin : g_first
            always_ff @(posedge clk) begin
                if (rst) chain[0] <= IDLE_LVL;
                else     chain[0] <= pin;
            end
        end else begin : g_next
            always_ff @(posedge clk) begin
                if (rst) chain[i] <= IDLE_LVL;
                else     chain[i] <= chain[i-1];
            end
        end
    end

    // Normalise polarity so that 1 always means "requesting reset"
    always_comb act_lvl = ACTIVE_HIGH ? chain[LAST] : ~chain[LAST];

    always_ff @(posedge clk) begin
        if (rst) act_prev <= 1'b0;
        else     act_prev <= act_lvl;
    end

    // Only the transition into the active level counts
    always_comb trig = act_lvl & ~act_prev;

    AST_EDGE_SINGLE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        trig |=> !trig);  // R6

endmodule

// File: rtl/supv_timer.sv
module supv_timer
    import supv_pkg::*;
#(
    parameter int unsigned TIMEOUT_CYC = 20_000_000
) (
    input  logic        clk,
    input  logic        rst,
    input  supv_cause_t cause,
    output logic        active_nxt
);
    localparam int unsigned CNT_W = cnt_width(TIMEOUT_CYC);
    localparam logic [CNT_W-1:0] LOAD = CNT_W'(TIMEOUT_CYC);

    tm_state_e        st_q, st_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;

    always_comb begin
        st_d  = st_q;
        cnt_d = cnt_q;
        if (cause.supply_low) begin
            st_d  = TM_HOLD;
            cnt_d = LAST_LOAD();
        end else if (cause_restarts(cause)) begin
            st_d  = TM_COUNT;
            cnt_d = LOAD;
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - 1'b1;
            st_d  = (cnt_d == '0) ? TM_IDLE : TM_COUNT;
        end else begin
            st_d  = TM_IDLE;
        end
    end

    function automatic logic [CNT_W-1:0] LAST_LOAD();
        return LOAD;
    endfunction

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q  <= TM_HOLD;
            cnt_q <= LOAD;
        end else begin
            st_q  <= st_d;
            cnt_q <= cnt_d;
        end
    end

    always_comb active_nxt = (st_d != TM_IDLE);

    AST_CNT_WITHIN_LOAD: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= LOAD);  // R8

    AST_IDLE_MEANS_DONE: assert property (@(posedge clk) disable iff (rst)
        (st_q == TM_IDLE) |-> (cnt_q == '0));  // R2

    AST_HOLD_PARKS_COUNT: assert property (@(posedge clk) disable iff (rst)
        cause.supply_low |=> (st_q == TM_HOLD) && (cnt_q == LOAD));  // R1

endmodule

// File: rtl/supv_out_stage.sv
module supv_out_stage (
    input  logic clk,
    input  logic rst,
    input  logic active_nxt,
    output logic rst_out_hi,
    output logic rst_out_lo,
    output logic busy
);
    // Three separate flops, all forced active during the block's own reset
    always_ff @(posedge clk) begin
        if (rst) begin
            rst_out_hi <= 1'b1;
            rst_out_lo <= 1'b0;
            busy       <= 1'b1;
        end else begin
            rst_out_hi <= active_nxt;
            rst_out_lo <= ~active_nxt;
            busy       <= active_nxt;
        end
    end

    AST_OUTPUTS_COMPLEMENT: assert property (@(posedge clk) disable iff (rst)
        rst_out_hi != rst_out_lo);  // R9

    AST_BUSY_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
        busy == rst_out_hi);  // R9

endmodule

// File: rtl/supv_rst_gen.sv
module supv_rst_gen
    import supv_pkg::*;
#(
    parameter int unsigned TIMEOUT_CYC = 20_000_000,
    parameter int unsigned SYNC_STAGES = SUPV_SYNC_DEFAULT
) (
    input  logic clk,
    input  logic rst,
    input  logic supply_ok,
    input  logic mr_n_pin,
    input  logic mr_pin,
    input  logic wdt_expire,
    output logic rst_out_hi,
    output logic rst_out_lo,
    output logic busy
);
    logic        trig_lo;
    logic        trig_hi;
    logic        active_nxt;
    supv_cause_t cause;

    supv_mr_edge #(
        .SYNC_STAGES (SYNC_STAGES),
        .ACTIVE_HIGH (1'b0)
    ) u_edge_lo (
        .clk  (clk),
        .rst  (rst),
        .pin  (mr_n_pin),
        .trig (trig_lo)
    );

    supv_mr_edge #(
        .SYNC_STAGES (SYNC_STAGES),
        .ACTIVE_HIGH (1'b1)
    ) u_edge_hi (
        .clk  (clk),
        .rst  (rst),
        .pin  (mr_pin),
        .trig (trig_hi)
    );

    always_comb begin
        cause.supply_low = ~supply_ok;
        cause.manual     = trig_lo | trig_hi;
        cause.watchdog   = wdt_expire;
    end

    supv_timer #(
        .TIMEOUT_CYC (TIMEOUT_CYC)
    ) u_timer (
        .clk        (clk),
        .rst        (rst),
        .cause      (cause),
        .active_nxt (active_nxt)
    );

    supv_out_stage u_out (
        .clk        (clk),
        .rst        (rst),
        .active_nxt (active_nxt),
        .rst_out_hi (rst_out_hi),
        .rst_out_lo (rst_out_lo),
        .busy       (busy)
    );

    AST_LOW_SUPPLY_ASSERTS: assert property (@(posedge clk) disable iff (rst)
        !supply_ok |=> rst_out_hi && !rst_out_lo && busy);  // R1

    AST_MANUAL_ASSERTS: assert property (@(posedge clk) disable iff (rst)
        (trig_lo || trig_hi) |=> rst_out_hi);  // R4

    AST_WATCHDOG_ASSERTS: assert property (@(posedge clk) disable iff (rst)
        wdt_expire |=> rst_out_hi);  // R7

    AST_RELEASE_NEEDS_SUPPLY: assert property (@(posedge clk) disable iff (rst)
        $fell(rst_out_hi) |-> $past(supply_ok));  // R2

endmodule

// File: tb/supv_rst_gen_tb.sv
module supv_rst_gen_tb;
    localparam int T    = 16;
    localparam int SYNC = 2;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic rst, supply_ok, mr_n_pin, mr_pin, wdt_expire;
    logic rst_out_hi, rst_out_lo, busy;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    supv_rst_gen #(
        .TIMEOUT_CYC (T),
        .SYNC_STAGES (SYNC)
    ) u_dut (
        .clk        (clk),
        .rst        (rst),
        .supply_ok  (supply_ok),
        .mr_n_pin   (mr_n_pin),
        .mr_pin     (mr_pin),
        .wdt_expire (wdt_expire),
        .rst_out_hi (rst_out_hi),
        .rst_out_lo (rst_out_lo),
        .busy       (busy)
    );

    // Each step passes exactly one rising edge; sampling is on the falling edge
    task automatic step(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic expect_rst(string req, logic exp);
        checks++;
        if (rst_out_hi !== exp || rst_out_lo !== ~exp || busy !== exp) begin
            errors++;
            $display("FAIL %s: hi=%b lo=%b busy=%b expected hi=%b lo=%b busy=%b",
                     req, rst_out_hi, rst_out_lo, busy, exp, ~exp, exp);
        end
    endtask

    task automatic t_reset_state();
        rst = 1'b1; supply_ok = 1'b0; mr_n_pin = 1'b1; mr_pin = 1'b0; wdt_expire = 1'b0;
        step(3);
        expect_rst("R10 reset state", 1'b1);
        rst = 1'b0;
        step(2);
        expect_rst("R1 supply low after reset", 1'b1);
    endtask

    task automatic t_powerup();
        supply_ok = 1'b1;
        step(T - 1);
        expect_rst("R2 still held one edge before release", 1'b1);
        step(1);
        expect_rst("R2 released at timeout", 1'b0);
    endtask

    task automatic t_brownout();
        step(4);
        supply_ok = 1'b0;
        step(1);
        expect_rst("R3 immediate assert on drop", 1'b1);
        step(5);
        expect_rst("R1 held while supply low", 1'b1);
        supply_ok = 1'b1;
        step(T - 1);
        expect_rst("R2 held after recovery", 1'b1);
        step(1);
        expect_rst("R2 release after recovery", 1'b0);
    endtask

    task automatic t_manual_hi();
        mr_pin = 1'b1;
        step(SYNC);
        expect_rst("R5 not yet through synchroniser", 1'b0);
        step(1);
        expect_rst("R5 asserted by rising edge", 1'b1);
        step(T - 1);
        expect_rst("R5 held for full timeout", 1'b1);
        step(1);
        expect_rst("R6 released although input held", 1'b0);
        step(10);
        expect_rst("R6 held level does not retrigger", 1'b0);
        mr_pin = 1'b0;
        step(SYNC + 3);
        expect_rst("R6 trailing edge ignored", 1'b0);
    endtask

    task automatic t_manual_lo();
        mr_n_pin = 1'b0;
        step(SYNC);
        expect_rst("R4 not yet through synchroniser", 1'b0);
        step(1);
        expect_rst("R4 asserted by falling edge", 1'b1);
        step(T - 1);
        expect_rst("R4 held for full timeout", 1'b1);
        step(1);
        expect_rst("R4 released although input held", 1'b0);
        mr_n_pin = 1'b1;
        step(SYNC + 3);
        expect_rst("R6 rising edge on low pin ignored", 1'b0);
    endtask

    task automatic t_watchdog();
        wdt_expire = 1'b1;
        step(1);
        wdt_expire = 1'b0;
        expect_rst("R7 asserted by watchdog", 1'b1);
        step(T - 1);
        expect_rst("R7 held for timeout", 1'b1);
        step(1);
        expect_rst("R7 released", 1'b0);
    endtask

    task automatic t_restart();
        mr_pin = 1'b1;
        step(SYNC + 1);
        expect_rst("R8 first trigger active", 1'b1);
        step(5);
        wdt_expire = 1'b1;
        step(1);
        wdt_expire = 1'b0;
        step(T - 1);
        expect_rst("R8 count restarted by second trigger", 1'b1);
        step(1);
        expect_rst("R8 release after restarted count", 1'b0);
        mr_pin = 1'b0;
        step(SYNC + 2);
        expect_rst("R9 idle outputs consistent", 1'b0);
    endtask

    task automatic t_midrun_reset();
        rst = 1'b1;
        step(1);
        expect_rst("R10 block reset asserts outputs", 1'b1);
        rst = 1'b0;
        step(T - 1);
        expect_rst("R10 held after block reset", 1'b1);
        step(1);
        expect_rst("R10 released after block reset", 1'b0);
    endtask

    initial begin
        t_reset_state();
        t_powerup();
        t_brownout();
        t_manual_hi();
        t_manual_lo();
        t_watchdog();
        t_restart();
        t_midrun_reset();
        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: run incomplete=1 expected 0");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule